// File: doc/BRIEF.md
# DMA Bus Handover and Snoop Controller

This block sits on the processor side of a shared bus and hands the bus to a DMA master on request. A request is taken while the processor is idle on the bus side. The processor is stalled at once. The grant is held back until the processor reports that its current bus cycle has ended. Once granted, the block waits for the master's acknowledge before it treats the bus as owned by DMA. If the acknowledge does not arrive within a configurable number of cycles, the block withdraws the grant and returns to idle.

While DMA owns the bus, every DMA write is looked up in a small direct-mapped tag store that mirrors the processor's cached lines. On a hit, a mode input chooses the action. Invalidate mode clears the entry's valid bit. Update mode keeps the entry valid and issues a one-cycle write toward the cache data array. DMA reads never change any state. When the master raises release, the block answers with a one-cycle release acknowledge and then drops the processor stall, so the processor resumes where it stopped.

Top module: `dma_snoop_ctrl`

## Requirements
- R1: After reset, `bus_grant`, `release_ack`, `cpu_stall` and `cw_en` are low and every tag entry is invalid (`probe_hit` is 0 for any address).
- R2: A `bus_req` sampled high while idle makes `cpu_stall` high from the next cycle on.
- R3: `bus_grant` stays low while `cpu_cycle_busy` is high. It rises the cycle after the first clock edge at which the block is waiting and `cpu_cycle_busy` is low.
- R4: If `grant_ack` is never seen, `bus_grant` stays high for exactly ACK_TIMEOUT cycles and then drops together with `cpu_stall`.
- R5: Snooping applies only after the acknowledge and before release. A write seen while idle or while granted but not yet acknowledged changes no entry and produces no `cw_en`.
- R6: Addresses split as offset = bit 0, index = bits 3..1 and tag = bits 15..4. A DMA write in invalidate mode (`upd_mode`=0) whose index and tag match a valid entry clears that entry. A tag mismatch leaves the entry unchanged.
- R7: A DMA write hit in update mode (`upd_mode`=1) leaves the entry valid. In the next cycle it raises `cw_en` for exactly one cycle, carrying the write's index, offset and data.
- R8: A DMA read (`snoop_wr`=0) changes no entry and produces no `cw_en`.
- R9: A `bus_release` sampled during DMA makes `release_ack` high for exactly one cycle, starting the next cycle. `bus_grant` is low from that same cycle.
- R10: `cpu_stall` drops in the cycle after `release_ack`.
- R11: `fill_en` loads the entry at the fill address's index with its tag and sets it valid, but only while idle. A fill during a handover is ignored.
- R12: A DMA write presented in the same cycle as `bus_release` is still snooped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | DMA master requests the bus |
| cpu_cycle_busy | input | 1 | Processor bus cycle still in progress |
| bus_grant | output | 1 | Bus granted to the DMA master |
| grant_ack | input | 1 | Master acknowledges the grant |
| bus_release | input | 1 | Master gives the bus back |
| release_ack | output | 1 | One-cycle acknowledge of the release |
| cpu_stall | output | 1 | Holds the processor off the bus |
| snoop_valid | input | 1 | A DMA transfer is on the bus this cycle |
| snoop_wr | input | 1 | Transfer is a write (1) or a read (0) |
| snoop_addr | input | 16 | Transfer address |
| snoop_data | input | 8 | Transfer write data |
| upd_mode | input | 1 | Hit action: 0 invalidate, 1 update |
| fill_en | input | 1 | Processor loads a line into the tag store |
| fill_addr | input | 16 | Address of the loaded line |
| probe_addr | input | 16 | Address looked up for `probe_hit` |
| probe_hit | output | 1 | Combinational hit for `probe_addr` |
| cw_en | output | 1 | Cache data write strobe for an update hit |
| cw_index | output | 3 | Entry index of the cache data write |
| cw_offset | output | 1 | Offset within the line |
| cw_data | output | 8 | Data to write |

## Verification
Two functions can fall in the same cycle: the release handshake and snooping. The bench puts a final DMA write that hits in invalidate mode on the bus in the very cycle it raises `bus_release`. It then checks that `release_ack` appears for one cycle, that the grant falls and that the probed entry reads back invalid. The tag store is swept over all eight indexes in both modes, with hits and same-index tag misses. The expected valid and tag contents are computed from the address split.

// File: rtl/dma_snoop_pkg.sv
package dma_snoop_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 8;
    localparam int IDX_W   = 3;
    localparam int OFF_W   = 1;
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int N_ENTRY = 1 << IDX_W;

    typedef enum logic [2:0] {
        HS_IDLE,
        HS_WAIT_END,
        HS_GRANTED,
        HS_DMA,
        HS_REL_ACK
    } hand_state_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [IDX_W-1:0] idx;
        logic [OFF_W-1:0] off;
    } addr_fields_t;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [OFF_W-1:0]  off;
        logic [DATA_W-1:0] data;
    } line_write_t;

    function automatic addr_fields_t split_addr(input logic [ADDR_W-1:0] a);
        return addr_fields_t'(a);
    endfunction
endpackage

// File: rtl/dma_handover_fsm.sv
module dma_handover_fsm
    import dma_snoop_pkg::*;
#(
    parameter int ACK_TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_req,
    input  logic cpu_cycle_busy,
    input  logic grant_ack,
    input  logic bus_release,
    output logic bus_grant,
    output logic release_ack,
    output logic cpu_stall,
    output logic dma_owns,
    output logic is_idle
);
    localparam int CNT_W = $clog2(ACK_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_TIMEOUT - 1);

    hand_state_e state_q, state_d;
    logic [CNT_W-1:0] wait_cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HS_IDLE:     if (bus_req) state_d = HS_WAIT_END;
            HS_WAIT_END: if (!cpu_cycle_busy) state_d = HS_GRANTED;
            HS_GRANTED: begin
                if (grant_ack) state_d = HS_DMA;
                else if (wait_cnt_q == CNT_LAST) state_d = HS_IDLE;
            end
            HS_DMA:      if (bus_release) state_d = HS_REL_ACK;
            HS_REL_ACK:  state_d = HS_IDLE;
            default:     state_d = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= HS_IDLE;
            wait_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == HS_GRANTED && state_d == HS_GRANTED)
                wait_cnt_q <= wait_cnt_q + CNT_W'(1);
            else
                wait_cnt_q <= '0;
        end
    end

    assign bus_grant   = (state_q == HS_GRANTED) || (state_q == HS_DMA);
    assign release_ack = (state_q == HS_REL_ACK);
    assign cpu_stall   = (state_q != HS_IDLE);
    assign dma_owns    = (state_q == HS_DMA);
    assign is_idle     = (state_q == HS_IDLE);

    // Independent run-length monitor of an unacknowledged grant
    logic [CNT_W:0] unacked_run_q;
    always_ff @(posedge clk) begin
        if (rst) unacked_run_q <= '0;
        else if (bus_grant && !dma_owns) unacked_run_q <= unacked_run_q + (CNT_W+1)'(1);
        else unacked_run_q <= '0;
    end

    p_stall_on_req_r2: assert property (@(posedge clk) disable iff (rst)
        (is_idle && bus_req) |=> cpu_stall);
    p_grant_after_cycle_end_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_grant) |-> $past(!cpu_cycle_busy));
    p_timeout_bound_r4: assert property (@(posedge clk) disable iff (rst)
        unacked_run_q <= (CNT_W+1)'(ACK_TIMEOUT));
    p_single_release_ack_r9: assert property (@(posedge clk) disable iff (rst)
        release_ack |=> !release_ack);
    p_no_grant_in_ack_r9: assert property (@(posedge clk) disable iff (rst)
        release_ack |-> !bus_grant);
    p_stall_drops_r10: assert property (@(posedge clk) disable iff (rst)
        release_ack |=> !cpu_stall);
endmodule

// File: rtl/snoop_tag_store.sv
module snoop_tag_store
    import dma_snoop_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              snp_en,
    input  logic              snp_wr,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_data,
    input  logic              upd_mode,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output line_write_t       line_wr
);
    addr_fields_t fill_f, snp_f, probe_f;
    assign fill_f  = split_addr(fill_addr);
    assign snp_f   = split_addr(snp_addr);
    assign probe_f = split_addr(probe_addr);

    logic [N_ENTRY-1:0] valid_vec;
    logic [TAG_W-1:0]   tag_vec [N_ENTRY];

    logic snp_hit, inval_hit, upd_hit;
    assign snp_hit   = valid_vec[snp_f.idx] && (tag_vec[snp_f.idx] == snp_f.tag);
    assign inval_hit = snp_en && snp_wr && snp_hit && !upd_mode;
    assign upd_hit   = snp_en && snp_wr && snp_hit && upd_mode;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                t_q <= '0;
            end else if (fill_en && fill_f.idx == IDX_W'(g)) begin
                v_q <= 1'b1;
                t_q <= fill_f.tag;
            end else if (inval_hit && snp_f.idx == IDX_W'(g)) begin
                v_q <= 1'b0;
            end
        end
        assign valid_vec[g] = v_q;
        assign tag_vec[g]   = t_q;
    end

    assign probe_hit = valid_vec[probe_f.idx] && (tag_vec[probe_f.idx] == probe_f.tag);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_wr <= '0;
        end else begin
            line_wr.en   <= upd_hit;
            line_wr.idx  <= snp_f.idx;
            line_wr.off  <= snp_f.off;
            line_wr.data <= snp_data;
        end
    end

    p_read_keeps_state_r8: assert property (@(posedge clk) disable iff (rst)
        (snp_en && !snp_wr && !fill_en) |=> $stable(valid_vec));
    p_inval_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (inval_hit && !fill_en) |=> !valid_vec[$past(snp_addr[IDX_W+OFF_W-1:OFF_W])]);
    p_update_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_hit && !fill_en) |=> (valid_vec[$past(snp_addr[IDX_W+OFF_W-1:OFF_W])] && line_wr.en));
    p_line_wr_source_r7: assert property (@(posedge clk) disable iff (rst)
        line_wr.en |-> $past(snp_en && snp_wr && upd_mode));
endmodule

// File: rtl/dma_snoop_ctrl.sv
module dma_snoop_ctrl
    import dma_snoop_pkg::*;
#(
    parameter int ACK_TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              cpu_cycle_busy,
    output logic              bus_grant,
    input  logic              grant_ack,
    input  logic              bus_release,
    output logic              release_ack,
    output logic              cpu_stall,
    input  logic              snoop_valid,
    input  logic              snoop_wr,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic [DATA_W-1:0] snoop_data,
    input  logic              upd_mode,
    input  logic              fill_en,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              probe_hit,
    output logic              cw_en,
    output logic [IDX_W-1:0]  cw_index,
    output logic [OFF_W-1:0]  cw_offset,
    output logic [DATA_W-1:0] cw_data
);
    logic dma_owns, is_idle;
    line_write_t line_wr;

    dma_handover_fsm #(.ACK_TIMEOUT(ACK_TIMEOUT)) u_fsm (
        .clk            (clk),
        .rst            (rst),
        .bus_req        (bus_req),
        .cpu_cycle_busy (cpu_cycle_busy),
        .grant_ack      (grant_ack),
        .bus_release    (bus_release),
        .bus_grant      (bus_grant),
        .release_ack    (release_ack),
        .cpu_stall      (cpu_stall),
        .dma_owns       (dma_owns),
        .is_idle        (is_idle)
    );

    snoop_tag_store u_tags (
        .clk        (clk),
        .rst        (rst),
        .fill_en    (fill_en && is_idle),
        .fill_addr  (fill_addr),
        .snp_en     (snoop_valid && dma_owns),
        .snp_wr     (snoop_wr),
        .snp_addr   (snoop_addr),
        .snp_data   (snoop_data),
        .upd_mode   (upd_mode),
        .probe_addr (probe_addr),
        .probe_hit  (probe_hit),
        .line_wr    (line_wr)
    );

    assign cw_en     = line_wr.en;
    assign cw_index  = line_wr.idx;
    assign cw_offset = line_wr.off;
    assign cw_data   = line_wr.data;

    p_snoop_only_dma_r5: assert property (@(posedge clk) disable iff (rst)
        !dma_owns |=> !cw_en);
    p_cw_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        (cw_en && !(snoop_valid && dma_owns)) |=> !cw_en);
endmodule

// File: tb/sim_dma_snoop_ctrl.sv
module sim_dma_snoop_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst;
    logic bus_req, cpu_cycle_busy, grant_ack, bus_release;
    logic bus_grant, release_ack, cpu_stall;
    logic snoop_valid, snoop_wr, upd_mode, fill_en;
    logic [15:0] snoop_addr, fill_addr, probe_addr;
    logic [7:0]  snoop_data;
    logic probe_hit, cw_en;
    logic [2:0] cw_index;
    logic [0:0] cw_offset;
    logic [7:0] cw_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic        exp_v [8];
    logic [11:0] exp_t [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_snoop_ctrl #(.ACK_TIMEOUT(TMO)) u0 (
        .clk(clk), .rst(rst), .bus_req(bus_req), .cpu_cycle_busy(cpu_cycle_busy),
        .bus_grant(bus_grant), .grant_ack(grant_ack), .bus_release(bus_release),
        .release_ack(release_ack), .cpu_stall(cpu_stall), .snoop_valid(snoop_valid),
        .snoop_wr(snoop_wr), .snoop_addr(snoop_addr), .snoop_data(snoop_data),
        .upd_mode(upd_mode), .fill_en(fill_en), .fill_addr(fill_addr),
        .probe_addr(probe_addr), .probe_hit(probe_hit), .cw_en(cw_en),
        .cw_index(cw_index), .cw_offset(cw_offset), .cw_data(cw_data)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_addr(logic [11:0] tg, int idx, int off);
        return {tg, 3'(idx), 1'(off)};
    endfunction

    task automatic probe_chk(string req, logic [15:0] a, logic exp);
        probe_addr = a;
        #1;
        chk(req, {31'd0, probe_hit}, {31'd0, exp});
    endtask

    task automatic check_all(string req);
        for (int i = 0; i < 8; i++)
            probe_chk(req, mk_addr(exp_t[i], i, 0), exp_v[i]);
    endtask

    task automatic snoop(logic wr, logic [15:0] a, logic [7:0] d, logic mode);
        snoop_valid = 1'b1; snoop_wr = wr; snoop_addr = a; snoop_data = d; upd_mode = mode;
        tick();
        snoop_valid = 1'b0; snoop_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        rst = 1'b1;
        bus_req = 0; cpu_cycle_busy = 0; grant_ack = 0; bus_release = 0;
        snoop_valid = 0; snoop_wr = 0; snoop_addr = 0; snoop_data = 0;
        upd_mode = 0; fill_en = 0; fill_addr = 0; probe_addr = 0;
        for (int i = 0; i < 8; i++) begin
            exp_v[i] = 1'b0;
            exp_t[i] = 12'hA00 + 12'(i * 7);
        end
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        chk("R1 grant", {31'd0, bus_grant}, 0);
        chk("R1 release_ack", {31'd0, release_ack}, 0);
        chk("R1 stall", {31'd0, cpu_stall}, 0);
        chk("R1 cw_en", {31'd0, cw_en}, 0);
        check_all("R1 entries invalid");

        // R11 fill every index while idle
        for (int i = 0; i < 8; i++) begin
            fill_en = 1'b1; fill_addr = mk_addr(exp_t[i], i, i % 2);
            tick();
            fill_en = 1'b0;
            exp_v[i] = 1'b1;
        end
        check_all("R11 fill");

        // R2/R3 handover with the processor cycle still busy
        cpu_cycle_busy = 1'b1; bus_req = 1'b1;
        tick();
        bus_req = 1'b0;
        chk("R2 stall", {31'd0, cpu_stall}, 1);
        chk("R3 no grant while busy", {31'd0, bus_grant}, 0);
        tick(); tick();
        chk("R3 still no grant", {31'd0, bus_grant}, 0);
        cpu_cycle_busy = 1'b0;
        tick();
        chk("R3 grant after cycle end", {31'd0, bus_grant}, 1);

        // R5 write before acknowledge is not snooped
        snoop(1'b1, mk_addr(exp_t[0], 0, 0), 8'h11, 1'b0);
        chk("R5 pre-ack cw_en", {31'd0, cw_en}, 0);
        probe_chk("R5 pre-ack entry kept", mk_addr(exp_t[0], 0, 0), 1'b1);
        grant_ack = 1'b1;
        tick();
        grant_ack = 1'b0;
        chk("R3 grant held in DMA", {31'd0, bus_grant}, 1);

        // R11 fill during DMA ignored
        fill_en = 1'b1; fill_addr = mk_addr(12'h123, 5, 0);
        tick();
        fill_en = 1'b0;
        probe_chk("R11 fill ignored new", mk_addr(12'h123, 5, 0), 1'b0);
        probe_chk("R11 fill ignored old", mk_addr(exp_t[5], 5, 0), 1'b1);

        // R6/R7 sweep over all indexes
        for (int i = 0; i < 8; i++) begin
            logic mode, hit;
            logic [11:0] tg;
            mode = (i >= 4);
            hit  = (i < 4) ? (i % 2 == 0) : (i != 7);
            tg   = hit ? exp_t[i] : exp_t[i] + 12'd1;
            snoop(1'b1, mk_addr(tg, i, i % 2), 8'h30 + 8'(i), mode);
            if (!mode && hit) exp_v[i] = 1'b0;
            if (mode) begin
                chk("R7 cw_en", {31'd0, cw_en}, {31'd0, hit});
                if (hit) begin
                    chk("R7 cw_index", {29'd0, cw_index}, i);
                    chk("R7 cw_offset", {31'd0, cw_offset}, i % 2);
                    chk("R7 cw_data", {24'd0, cw_data}, 32'h30 + i);
                end
            end else begin
                chk("R6 no cw_en", {31'd0, cw_en}, 0);
            end
            tick();
            chk("R7 cw one cycle", {31'd0, cw_en}, 0);
            probe_chk(mode ? "R7 entry" : "R6 entry", mk_addr(exp_t[i], i, 0), exp_v[i]);
        end

        // R8 DMA reads
        snoop(1'b0, mk_addr(exp_t[1], 1, 1), 8'h55, 1'b0);
        chk("R8 read cw_en", {31'd0, cw_en}, 0);
        probe_chk("R8 read keeps inval", mk_addr(exp_t[1], 1, 0), 1'b1);
        snoop(1'b0, mk_addr(exp_t[4], 4, 0), 8'h66, 1'b1);
        chk("R8 read no update", {31'd0, cw_en}, 0);
        probe_chk("R8 read keeps upd", mk_addr(exp_t[4], 4, 0), 1'b1);

        // R12 final write together with release
        bus_release = 1'b1;
        snoop_valid = 1'b1; snoop_wr = 1'b1; upd_mode = 1'b0;
        snoop_addr = mk_addr(exp_t[3], 3, 1); snoop_data = 8'h77;
        tick();
        bus_release = 1'b0; snoop_valid = 1'b0; snoop_wr = 1'b0;
        exp_v[3] = 1'b0;
        chk("R9 release_ack", {31'd0, release_ack}, 1);
        chk("R9 grant low", {31'd0, bus_grant}, 0);
        chk("R10 stall held", {31'd0, cpu_stall}, 1);
        probe_chk("R12 write with release", mk_addr(exp_t[3], 3, 0), 1'b0);
        tick();
        chk("R9 release_ack one cycle", {31'd0, release_ack}, 0);
        chk("R10 stall dropped", {31'd0, cpu_stall}, 0);
        check_all("R6 final contents");

        // R4 acknowledge timeout
        bus_req = 1'b1;
        tick();
        bus_req = 1'b0;
        tick();
        n = 0;
        while (bus_grant && n < 100) begin
            n++;
            tick();
        end
        chk("R4 grant length", n, TMO);
        chk("R4 stall after timeout", {31'd0, cpu_stall}, 0);

        // R5 writes while idle
        snoop(1'b1, mk_addr(exp_t[1], 1, 0), 8'h88, 1'b0);
        probe_chk("R5 idle write", mk_addr(exp_t[1], 1, 0), 1'b1);
        snoop(1'b1, mk_addr(exp_t[5], 5, 0), 8'h99, 1'b1);
        chk("R5 idle no cw_en", {31'd0, cw_en}, 0);
        check_all("R5 contents");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule